// File: doc/BRIEF.md
# Multi-Channel Interrupt Status and Mask

This block merges the transmit-ready and receive-ready levels of several serial channels into one status byte and raises a single active-low interrupt request line. Each channel owns a four-bit slice of the byte. The transmit flag sits at the bottom bit of the slice and the receive flag at the next bit up. The two upper bits of each slice are held for timer and input-change sources that are not built here, and they always read zero.

One register address serves two purposes. A read at that address returns the live status. A write at that address loads an enable mask, which uses the same bit layout. The request line is driven by a small two-state machine. It enters `REQ_ACTIVE` when any status bit and its mask bit are both set, and returns to `REQ_IDLE` when no such pair remains. The transitions are named *raise* (IDLE to ACTIVE) and *drop* (ACTIVE to IDLE). The host sees a falling edge on the line when a request begins.

Because the status bits are live levels, a condition that clears also clears its status bit. Software needs no acknowledge write.

Top module: `int_status_mask`

## Requirements
- R1: When a read is strobed at address 5, status bit 4x equals channel x's transmit-ready input and bit 4x+1 equals its receive-ready input.
- R2: Status bits at positions 4x+2 and 4x+3 always read zero.
- R3: Status bits follow the inputs without latching: once a ready input falls, the next read shows its bit as zero.
- R4: A write strobed at address 5 loads the mask from the write data at the next clock edge. A read at address 5 returns status, never the mask.
- R5: The request line goes low on the clock edge after any status bit and its matching mask bit are both 1 (the *raise* transition into REQ_ACTIVE).
- R6: A status bit whose mask bit is 0 does not drive the request line low.
- R7: When no status bit is paired with a set mask bit, the line returns high on the next edge (the *drop* transition). Writing zero to the mask therefore releases it.
- R8: Reset clears the mask, puts the state machine in REQ_IDLE and drives the request line high.
- R9: A read at any address other than 5 returns zero. A write at any other address leaves the mask unchanged.
- R10: A new mask reaches the request line one clock after the edge that loads it, so the line changes two edges after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_rdy | input | NUM_CH | Per-channel transmit-ready level |
| rx_rdy | input | NUM_CH | Per-channel receive-ready level |
| addr | input | ADDR_W | Register address of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 4*NUM_CH | Write data (mask value) |
| rd_data | output | 4*NUM_CH | Read data (status, or zero) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets four kinds of fault, each with a distinct symptom:

- **Channel-to-bit mapping.** A design with a wrong stride or swapped flags would show a channel's ready level at the wrong bit. The same fault would let the reserved bits carry data.
- **Masking.** A design that ignores the mask would pull the line low on a disabled source. The case where only reserved mask bits are set covers a design that ORs mask bits without pairing them with status.
- **Timing.** A design that registers status would leave a stale bit set after its source falls. A design with the wrong latency would move the line in the cycle before, or after, the one expected after a mask write.
- **Address decode and reset.** A design with loose decoding would load the mask on a write to a neighbouring address. A design that does not clear state on reset would leave the line low after a reset in the middle of a run.

// File: rtl/int_stat_pkg.sv
package int_stat_pkg;

    // Bits reserved to each channel in the shared status byte
    localparam int unsigned CH_STRIDE = 4;
    // Position of the transmit and receive flags inside a channel slice
    localparam int unsigned TX_SLOT   = 0;
    localparam int unsigned RX_SLOT   = 1;

    typedef enum logic [0:0] {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_t;

endpackage

// File: rtl/int_stat_gather.sv
module int_stat_gather
    import int_stat_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    localparam int unsigned STAT_W = CH_STRIDE * NUM_CH
) (
    input  logic [NUM_CH-1:0] tx_rdy,
    input  logic [NUM_CH-1:0] rx_rdy,
    output logic [STAT_W-1:0] status_v
);

    // Each channel fills its own slice; the reserved slots stay zero.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slice
        localparam int unsigned BASE = ch * CH_STRIDE;
        always_comb begin
            status_v[BASE +: CH_STRIDE]   = '0;
            status_v[BASE + TX_SLOT]      = tx_rdy[ch];
            status_v[BASE + RX_SLOT]      = rx_rdy[ch];
        end
    end

endmodule

// File: rtl/int_mask_reg.sv
module int_mask_reg #(
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STAT_W-1:0] din,
    output logic [STAT_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= din;
        end
    end

endmodule

// File: rtl/int_req_fsm.sv
module int_req_fsm
    import int_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_n
);

    req_state_t state_q;
    req_state_t state_d;

    // Transition logic: raise on any enabled source, drop when none remain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (pending)  state_d = REQ_ACTIVE;
            REQ_ACTIVE: if (!pending) state_d = REQ_IDLE;
            default:                  state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode: line is low only while a request is active
    always_comb begin
        unique case (state_q)
            REQ_ACTIVE: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/int_status_mask.sv
module int_status_mask
    import int_stat_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned REG_ADDR = 5,
    localparam int unsigned STAT_W  = CH_STRIDE * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tx_rdy,
    input  logic [NUM_CH-1:0] rx_rdy,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq_n
);

    logic              addr_hit;
    logic [STAT_W-1:0] status_v;
    logic [STAT_W-1:0] mask_q;
    logic              pending;

    assign addr_hit = (addr == ADDR_W'(REG_ADDR));

    int_stat_gather #(
        .NUM_CH (NUM_CH)
    ) u_gather (
        .tx_rdy   (tx_rdy),
        .rx_rdy   (rx_rdy),
        .status_v (status_v)
    );

    int_mask_reg #(
        .STAT_W (STAT_W)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_en && addr_hit),
        .din    (wr_data),
        .mask_q (mask_q)
    );

    assign pending = |(status_v & mask_q);

    int_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_n   (irq_n)
    );

    assign rd_data = (rd_en && addr_hit) ? status_v : '0;

endmodule

// File: rtl/int_status_mask_chk.sv
module int_status_mask_chk #(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned REG_ADDR = 5,
    parameter int unsigned STAT_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] tx_rdy,
    input logic [NUM_CH-1:0] rx_rdy,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [STAT_W-1:0] wr_data,
    input logic [STAT_W-1:0] rd_data,
    input logic              irq_n,
    input logic [STAT_W-1:0] status_v,
    input logic [STAT_W-1:0] mask_q
);

    logic [STAT_W-1:0] resv_bits;
    always_comb begin
        resv_bits = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            resv_bits[ch*4 + 2] = 1'b1;
            resv_bits[ch*4 + 3] = 1'b1;
        end
    end

    logic hit;
    assign hit = (addr == ADDR_W'(REG_ADDR));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_map
        // R1
        a_r1_tx_map: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && hit) |-> (rd_data[ch*4] == tx_rdy[ch]));
        a_r1_rx_map: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && hit) |-> (rd_data[ch*4 + 1] == rx_rdy[ch]));
    end

    a_r2_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & resv_bits) == '0);

    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (mask_q == $past(wr_data)));

    a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_v & mask_q)) |=> !irq_n);

    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_v & mask_q)) |=> irq_n);

    a_r9_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(mask_q));

    a_r9_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && hit) |-> (rd_data == '0));

endmodule

bind int_status_mask int_status_mask_chk #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .STAT_W   (STAT_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_rdy   (tx_rdy),
    .rx_rdy   (rx_rdy),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq_n    (irq_n),
    .status_v (status_v),
    .mask_q   (mask_q)
);

// File: tb/test_int_status_mask.sv
`timescale 1ns/1ps
module test_int_status_mask;

    localparam int NUM_CH = 2;
    localparam int STAT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] tx_rdy = '0;
    logic [NUM_CH-1:0] rx_rdy = '0;
    logic [3:0]        addr = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [STAT_W-1:0] wr_data = '0;
    logic [STAT_W-1:0] rd_data;
    logic              irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    int_status_mask i_int_status_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_rdy  (tx_rdy),
        .rx_rdy  (rx_rdy),
        .addr    (addr),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_n   (irq_n)
    );

    // {tx[1:0], rx[1:0], mask[7:0], expected status[7:0], expected irq_n}
    localparam logic [20:0] VEC [8] = '{
        {2'b00, 2'b00, 8'hFF, 8'h00, 1'b1},
        {2'b01, 2'b00, 8'h01, 8'h01, 1'b0},
        {2'b00, 2'b01, 8'h01, 8'h02, 1'b1},
        {2'b00, 2'b01, 8'h02, 8'h02, 1'b0},
        {2'b10, 2'b00, 8'h10, 8'h10, 1'b0},
        {2'b00, 2'b10, 8'h0F, 8'h20, 1'b1},
        {2'b11, 2'b11, 8'hCC, 8'h33, 1'b1},
        {2'b11, 2'b11, 8'h22, 8'h33, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [3:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #0.5;
        v = rd_data;
        rd_en = 1'b0; addr = 4'd0;
    endtask

    task automatic write_at(input logic [3:0] a, input logic [7:0] d);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'd0; wr_data = '0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 irq_n in reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        tx_rdy = 2'b11; rx_rdy = 2'b11;
        @(negedge clk); @(negedge clk);
        check("R8 mask clear after reset", {7'd0, irq_n}, 8'h01);
        tx_rdy = '0; rx_rdy = '0;

        // Vector walk: R1 R2 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            tx_rdy = VEC[i][20:19];
            rx_rdy = VEC[i][18:17];
            write_at(4'd5, VEC[i][16:9]);
            @(negedge clk);
            read_at(4'd5, v);
            check($sformatf("R1 R2 R4 status vec%0d", i), v, VEC[i][8:1]);
            check($sformatf("R5 R6 irq_n vec%0d", i), {7'd0, irq_n}, {7'd0, VEC[i][0]});
        end

        // R7: write zero releases the line
        write_at(4'd5, 8'h00);
        @(negedge clk);
        check("R7 zero mask releases", {7'd0, irq_n}, 8'h01);

        // R10: latency of a mask change
        tx_rdy = 2'b01; rx_rdy = 2'b00;
        write_at(4'd5, 8'h01);
        check("R10 line unchanged one edge after write", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        check("R10 line low two edges after write", {7'd0, irq_n}, 8'h00);

        // R3: live level clears with its source
        tx_rdy = 2'b00;
        read_at(4'd5, v);
        check("R3 status clears at once", v, 8'h00);
        check("R3 line still low same cycle", {7'd0, irq_n}, 8'h00);
        @(negedge clk);
        check("R3 line released next edge", {7'd0, irq_n}, 8'h01);

        // R9: foreign address access
        write_at(4'd5, 8'h00);
        tx_rdy = 2'b01;
        write_at(4'd4, 8'hFF);
        @(negedge clk);
        check("R9 foreign write ignored", {7'd0, irq_n}, 8'h01);
        read_at(4'd4, v);
        check("R9 foreign read zero", v, 8'h00);

        // R8: reset mid-run
        write_at(4'd5, 8'h01);
        @(negedge clk);
        check("R8 line low before reset", {7'd0, irq_n}, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 line high in reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R8 mask cleared by reset", {7'd0, irq_n}, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule